// File: doc/BRIEF.md
# Prescaled Reference Timer Channel

This block is one 16-bit up-counting timer channel with a small register set on a simple synchronous bus. Software can stop the channel, hold it cleared, set its count-rate divisors and load a reference value. The system clock passes through an optional divide-by-16 stage and then two 8-bit prescalers. Each tick at the end of this chain advances the counter by one. When a tick finds the counter equal to the reference value, a sticky event flag is set. An interrupt line follows that flag when the interrupt enable is set.

In restart mode the counter returns to zero on a match, which gives a periodic event every (reference+1) ticks. In free-run mode the counter continues past the reference and wraps at 0xFFFF. A capture register is present for software use only.

The run control is a three-state machine. CLEAR holds every count at zero. HALT freezes the counter and prescalers. RUN lets the prescaled ticks through. From any state the next state is CLEAR whenever the clear bit is set. Otherwise it is HALT when the halt bit is set, and RUN when neither bit is set. The transitions are named CLEAR→HALT, CLEAR→RUN, HALT→CLEAR, HALT→RUN, RUN→CLEAR and RUN→HALT. The state register follows the control register one cycle later.

Top module: `ptmr_channel`

## Requirements
- R1: After reset, the control byte reads 0x02 (halt set, clear not set). Mode, reference, capture, counter, event and primary prescale all read 0, and irq is low.
- R2: The register offsets on bus_addr are: 0 control (byte), 1 mode, 2 reference, 3 capture, 4 counter, 5 event, 6 primary prescale (bits [7:0]). Reads are combinational. Reference, capture and prescale read back the last value written. A counter write outside CLEAR loads the counter.
- R3: With PAIR_SLOT=0 the halt bit is control bit 1 and the clear bit is control bit 0. With PAIR_SLOT=1 they are bits 5 and 4. Clear takes priority over halt.
- R4: In HALT the counter and the prescaler counts keep their values.
- R5: In CLEAR the counter, the prescaler counts and the event flag are held at zero, and counter writes are ignored.
- R6: Mode bits [2:1] select the count source. With 01, the counter advances once every (psr+1)·(sps+1) clock cycles. With 10, it advances once every 16·(psr+1)·(sps+1) cycles. psr is the value in register 6 and sps is mode bits [15:8].
- R7: With mode bits [2:1] equal to 00 or 11, the counter does not advance.
- R8: On the tick at which the counter equals the reference, event bit 1 is set. With mode bit 3 set, the counter goes to 0 on that tick, so matches recur every (reference+1) ticks.
- R9: With mode bit 3 clear, the counter moves on to reference+1 after a match and wraps from 0xFFFF to 0x0000.
- R10: Writing event register bit 1 as 1 clears the flag, and writing it as 0 leaves the flag unchanged. A match in the same cycle as the clear keeps the flag set.
- R11: irq equals event bit 1 AND mode bit 4. It stays high until the flag is cleared or the enable is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Reference-match interrupt |

## Verification
The assertions check several rules on every cycle. The counter must stay frozen in HALT and between ticks, and must be zero after a CLEAR cycle. No tick may appear from a disabled source, and a restart match must return the counter to zero. The event flag must persist until it is cleared, and irq may never be high without it. The exact count rate for each combination of divisors and slow-go, the value after free-run and wrap-around matches, and the write-one-to-clear detail can only be shown by the bench. Its scenarios measure the cycles between consecutive events and read the counter at known points.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_HALT  = 2'd1,
        ST_RUN   = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SRC_CHAIN = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_SLOW  = 2'b10,
        SRC_RSVD  = 2'b11
    } clk_src_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_REF   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_EVENT = 3'd5;
    localparam logic [ADDR_W-1:0] A_PSCL  = 3'd6;

    localparam int MODE_SRC_LO  = 1;
    localparam int MODE_RESTART = 3;
    localparam int MODE_IRQ_EN  = 4;
    localparam int MODE_SPS_LO  = 8;
    localparam int EV_REF_BIT   = 1;

endpackage

// File: rtl/ptmr_ctrl_fsm.sv
module ptmr_ctrl_fsm
    import ptmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_req,
    input  logic       halt_req,
    output tmr_state_e state,
    output logic       run_en,
    output logic       hold_zero
);

    tmr_state_e state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLEAR: begin
                if (!clear_req) begin
                    state_nxt = halt_req ? ST_HALT : ST_RUN;
                end
            end
            ST_HALT: begin
                if (clear_req) begin
                    state_nxt = ST_CLEAR;
                end else if (!halt_req) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (clear_req) begin
                    state_nxt = ST_CLEAR;
                end else if (halt_req) begin
                    state_nxt = ST_HALT;
                end
            end
            default: state_nxt = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run_en    = 1'b0;
        hold_zero = 1'b0;
        unique case (state)
            ST_RUN:   run_en    = 1'b1;
            ST_CLEAR: hold_zero = 1'b1;
            ST_HALT:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
#(
    parameter int PS_W     = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            hold_zero,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] psr,
    input  logic [PS_W-1:0] sps,
    output logic            tick
);

    localparam int SLOW_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);

    logic [SLOW_W-1:0] slow_q;
    logic [PS_W-1:0]   pri_q;
    logic [PS_W-1:0]   sec_q;
    logic              slow_wrap;
    logic              base_tick;
    logic              pri_tick;

    always_comb begin
        slow_wrap = (slow_q == SLOW_LAST);
        unique case (src)
            SRC_SYS:  base_tick = run_en;
            SRC_SLOW: base_tick = run_en && slow_wrap;
            default:  base_tick = 1'b0;
        endcase
        // >= keeps the stage bounded if the divisor is lowered mid-count
        pri_tick = base_tick && (pri_q >= psr);
        tick     = pri_tick && (sec_q >= sps);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q <= '0;
            pri_q  <= '0;
            sec_q  <= '0;
        end else if (hold_zero) begin
            slow_q <= '0;
            pri_q  <= '0;
            sec_q  <= '0;
        end else begin
            if (run_en && (src == SRC_SLOW)) begin
                slow_q <= slow_wrap ? '0 : slow_q + 1'b1;
            end
            if (base_tick) begin
                pri_q <= pri_tick ? '0 : pri_q + 1'b1;
            end
            if (pri_tick) begin
                sec_q <= tick ? '0 : sec_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_zero,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    assign match = tick && (count == ref_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (hold_zero) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (tick) begin
            count <= (match && restart) ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PS_W      = 8,
    parameter int SLOW_DIV  = 16,
    parameter int PAIR_SLOT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int HALT_BIT = (PAIR_SLOT == 0) ? 1 : 5;
    localparam logic [7:0] CTRL_RST = 8'(1 << HALT_BIT);

    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] mode_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] capt_q;
    logic [PS_W-1:0]  psr_q;
    logic             ev_q;

    logic             clear_req;
    logic             halt_req;
    tmr_state_e       state;
    logic             run_en;
    logic             hold_zero;
    logic             pre_tick;
    logic [CNT_W-1:0] cnt_q;
    logic             ref_match;
    logic             cnt_wr;
    logic             ev_wr;
    logic             ev_clr_wr;
    clk_src_e         src_sel;

    generate
        if (PAIR_SLOT == 0) begin : g_slot_lo
            assign halt_req  = ctrl_q[1];
            assign clear_req = ctrl_q[0];
        end else begin : g_slot_hi
            assign halt_req  = ctrl_q[5];
            assign clear_req = ctrl_q[4];
        end
    endgenerate

    assign cnt_wr    = bus_we && (bus_addr == A_COUNT);
    assign ev_wr     = bus_we && (bus_addr == A_EVENT);
    assign ev_clr_wr = ev_wr && bus_wdata[EV_REF_BIT];
    assign src_sel   = clk_src_e'(mode_q[MODE_SRC_LO +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mode_q <= '0;
            ref_q  <= '0;
            capt_q <= '0;
            psr_q  <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[7:0];
                A_MODE:  mode_q <= bus_wdata;
                A_REF:   ref_q  <= bus_wdata;
                A_CAPT:  capt_q <= bus_wdata;
                A_PSCL:  psr_q  <= bus_wdata[PS_W-1:0];
                default: ;
            endcase
        end
    end

    // event flag: a match wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
        end else if (hold_zero) begin
            ev_q <= 1'b0;
        end else if (ref_match) begin
            ev_q <= 1'b1;
        end else if (ev_clr_wr) begin
            ev_q <= 1'b0;
        end
    end

    ptmr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_req (clear_req),
        .halt_req  (halt_req),
        .state     (state),
        .run_en    (run_en),
        .hold_zero (hold_zero)
    );

    ptmr_prescale #(
        .PS_W     (PS_W),
        .SLOW_DIV (SLOW_DIV)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .hold_zero (hold_zero),
        .src       (src_sel),
        .psr       (psr_q),
        .sps       (mode_q[MODE_SPS_LO +: PS_W]),
        .tick      (pre_tick)
    );

    ptmr_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (hold_zero),
        .tick      (pre_tick),
        .restart   (mode_q[MODE_RESTART]),
        .ref_val   (ref_q),
        .wr_en     (cnt_wr),
        .wr_data   (bus_wdata),
        .count     (cnt_q),
        .match     (ref_match)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata[7:0] = ctrl_q;
            A_MODE:  bus_rdata = mode_q;
            A_REF:   bus_rdata = ref_q;
            A_CAPT:  bus_rdata = capt_q;
            A_COUNT: bus_rdata = cnt_q;
            A_EVENT: bus_rdata[EV_REF_BIT] = ev_q;
            A_PSCL:  bus_rdata[PS_W-1:0] = psr_q;
            default: ;
        endcase
    end

    assign irq = ev_q && mode_q[MODE_IRQ_EN];

endmodule

// File: rtl/ptmr_channel_chk.sv
module ptmr_channel_chk
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input tmr_state_e       state,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ref_val,
    input logic             restart,
    input logic             cnt_wr,
    input clk_src_e         src,
    input logic             ev_flag,
    input logic             ev_clr,
    input logic             irq
);

    a_r4_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !cnt_wr) |=> $stable(count));

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (count == '0 && !ev_flag));

    a_r6_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && state != ST_CLEAR) |=> $stable(count));

    a_r7_src_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_CHAIN || src == SRC_RSVD) |-> !tick);

    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == ref_val && restart && !cnt_wr && state != ST_CLEAR)
        |=> (count == '0 && ev_flag));

    a_r10_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_flag && !ev_clr && state != ST_CLEAR) |=> ev_flag);

    a_r11_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ev_flag);

endmodule

bind ptmr_channel ptmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .tick    (pre_tick),
    .count   (cnt_q),
    .ref_val (ref_q),
    .restart (mode_q[3]),
    .cnt_wr  (cnt_wr),
    .src     (src_sel),
    .ev_flag (ev_q),
    .ev_clr  (ev_clr_wr),
    .irq     (irq)
);

// File: tb/ptmr_channel_tb_top.sv
`timescale 1ns/1ps
module ptmr_channel_tb_top;

    localparam logic [2:0] R_CTRL = 3'd0, R_MODE = 3'd1, R_REF = 3'd2, R_CAPT = 3'd3,
                           R_CNT = 3'd4, R_EV = 3'd5, R_PSR = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int    nchk = 0;
    int    nfail = 0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptmr_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic longint exp_period(int psr, int sps, bit slow, int rv);
        return longint'(rv + 1) * (psr + 1) * (sps + 1) * (slow ? 16 : 1);
    endfunction

    function automatic logic [15:0] mode_word(int sps, bit irq_en, bit rst_on_match, logic [1:0] src);
        return {8'(sps), 3'b000, irq_en, rst_on_match, src, 1'b0};
    endfunction

    task automatic check(string req, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic poll_ev(output longint t);
        logic [15:0] d;
        int n;
        n = 0;
        forever begin
            rd(R_EV, d);
            if (d[1]) break;
            @(negedge clk);
            n++;
            if (n > 40000) begin
                check("R8 event timeout", 0, 1);
                break;
            end
        end
        t = cyc;
    endtask

    task automatic setup(int psr, int sps, logic [1:0] src, bit rom, bit ien, int rv);
        wr(R_CTRL, 16'h0003);
        wr(R_PSR, 16'(psr));
        wr(R_MODE, mode_word(sps, ien, rom, src));
        wr(R_REF, 16'(rv));
        wr(R_EV, 16'hFFFF);
        wr(R_CTRL, 16'h0000);
    endtask

    task automatic period_test(string req, int psr, int sps, bit slow, int rv);
        longint t0, t1;
        setup(psr, sps, slow ? 2'b10 : 2'b01, 1'b1, 1'b0, rv);
        poll_ev(t0);
        wr(R_EV, 16'h0002);
        poll_ev(t1);
        check(req, t1 - t0, exp_period(psr, sps, slow, rv));
    endtask

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog act=expired exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] d, a;
        longint t;
        int unsigned seed;
        seed = $urandom(32'd4242);

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset values
        rd(R_CTRL, d); check("R1 ctrl", d, 16'h0002);
        rd(R_MODE, d); check("R1 mode", d, 0);
        rd(R_CNT, d);  check("R1 count", d, 0);
        rd(R_EV, d);   check("R1 event", d, 0);
        rd(R_PSR, d);  check("R1 psr", d, 0);
        check("R1 irq", irq, 0);

        // R2: register readback
        wr(R_REF, 16'hA5C3); rd(R_REF, d);  check("R2 ref", d, 16'hA5C3);
        wr(R_CAPT, 16'h1E2F); rd(R_CAPT, d); check("R2 capture", d, 16'h1E2F);
        wr(R_PSR, 16'hFF37); rd(R_PSR, d);  check("R2 psr", d, 16'h0037);

        // R6, R8: directed periods, system clock and slow-go
        period_test("R6 R8 div1", 0, 0, 1'b0, 4);
        period_test("R6 slow", 1, 2, 1'b1, 3);

        // R6: random divisor mixes
        for (int k = 0; k < 8; k++) begin
            int p, s, r;
            bit sl;
            p  = int'($urandom_range(3, 0));
            s  = int'($urandom_range(3, 0));
            sl = 1'($urandom_range(1, 0));
            r  = int'($urandom_range(8, 3));
            period_test("R6 random", p, s, sl, r);
        end

        // R8: restart returns to zero on the match tick
        setup(0, 0, 2'b01, 1'b1, 1'b0, 10);
        poll_ev(t);
        rd(R_CNT, d); check("R8 restart count", d, 0);

        // R9: free-run continues past reference
        setup(0, 0, 2'b01, 1'b0, 1'b0, 10);
        poll_ev(t);
        rd(R_CNT, d); check("R9 free-run count", d, 11);

        // R4, R3: halt bit 1 freezes the counter
        wr(R_CTRL, 16'h0002);
        idle(2);
        rd(R_CNT, a);
        idle(30);
        rd(R_CNT, d); check("R4 R3 halt hold", d, a);
        wr(R_CNT, 16'h1234); rd(R_CNT, d); check("R2 count write", d, 16'h1234);

        // R5, R3: clear bit 0 zeroes count and event, ignores writes
        wr(R_CTRL, 16'h0001);
        idle(2);
        rd(R_CNT, d); check("R5 R3 clear count", d, 0);
        rd(R_EV, d);  check("R5 clear event", d, 0);
        wr(R_CNT, 16'h0055); rd(R_CNT, d); check("R5 write ignored", d, 0);

        // R9: wrap 0xFFFF -> 0
        wr(R_CTRL, 16'h0002);
        idle(2);
        wr(R_MODE, mode_word(0, 1'b0, 1'b0, 2'b01));
        wr(R_REF, 16'd2);
        wr(R_CNT, 16'hFFFD);
        wr(R_EV, 16'hFFFF);
        wr(R_CTRL, 16'h0000);
        poll_ev(t);
        rd(R_CNT, d); check("R9 wrap", d, 3);

        // R7: disabled sources
        setup(0, 0, 2'b00, 1'b1, 1'b0, 3);
        idle(40);
        rd(R_CNT, d); check("R7 src00 count", d, 0);
        rd(R_EV, d);  check("R7 src00 event", d, 0);
        setup(0, 0, 2'b11, 1'b1, 1'b0, 3);
        idle(40);
        rd(R_CNT, d); check("R7 src11 count", d, 0);

        // R11, R10: interrupt and write-one-to-clear
        setup(0, 0, 2'b01, 1'b1, 1'b1, 5);
        poll_ev(t);
        check("R11 irq set", irq, 1);
        wr(R_CTRL, 16'h0002);
        idle(2);
        wr(R_EV, 16'h0000);
        rd(R_EV, d); check("R10 zero write keeps", d, 16'h0002);
        check("R11 irq held", irq, 1);
        wr(R_MODE, mode_word(0, 1'b0, 1'b1, 2'b01));
        #1;
        check("R11 irq masked", irq, 0);
        wr(R_EV, 16'h0002);
        rd(R_EV, d); check("R10 one clears", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule